// File: doc/BRIEF.md
# Machine Clock Mode Switch Controller

This block decides which source drives the machine clock: the main oscillator, the PLL output or the low-speed subclock. Software writes a small control word. The word holds two active-low select bits, a multiplier field for the PLL and a two-bit wait-select field. From the two select bits the block derives a requested mode. It does not switch at once. For each kind of change it first inserts the matching stabilization wait or synchronization step, and only then commits the new mode. The committed mode is reported as a binary status code and also as a one-hot clock-select vector, which a glitch-free clock multiplexer outside this block can use.

All counting runs on a single reference clock. A PLL lock wait has a fixed length. Waits that leave the subclock take their length from the wait-select field. A change into subclock mode has no long wait: it commits on the first subclock tick after that tick has passed through a short synchronizer chain. A one-cycle timebase-clear pulse comes out on the two changes that restart the timebase: main to PLL, and subclock to main. While the PLL is selected, writes to the multiplier field are ignored. If the request changes while a wait is running, that wait stops and a new one starts toward the new request.

Top module: `clk_mode_switch`

## Requirements
- R1: After reset, both select bits read 1, the multiplier field and the wait-select field read 0, the mode code is 0 (main), the clock-select vector is 3'b001, and busy and the timebase-clear pulse are both low.
- R2: The requested mode is subclock whenever the subclock select bit is 0, whatever the PLL select bit holds. Otherwise it is PLL when the PLL select bit is 0, and main when both bits are 1.
- R3: A change from main to PLL commits exactly 2^PLL_LOCK_LOG2 + 1 reference edges after the write edge. Busy is high from the edge after the write until the commit.
- R4: A change from subclock to PLL, or from subclock to main, commits 2^k + 1 edges after the write edge. Here k is WS0_LOG2, WS1_LOG2, WS2_LOG2 or WS3_LOG2, picked by wait-select value 0, 1, 2 or 3.
- R5: A change from main or from PLL to subclock never commits without a subclock tick. It commits SYNC_STAGES edges after the edge that samples a tick, provided the wait has started by then.
- R6: A change from PLL to main commits on the first edge after the write edge, and busy stays low.
- R7: The timebase-clear output is a one-cycle pulse. It rises at the commit of main to PLL and at the commit of subclock to main, and at no other time.
- R8: A write leaves the multiplier field unchanged when the PLL select bit held 0 just before that write. Otherwise the write loads the field.
- R9: If the request changes during a wait, the count restarts from the edge after the new write. If the request returns to the committed mode, the wait is dropped and busy falls on the next edge.
- R10: Mode codes are 0 for main, 1 for PLL and 2 for subclock. The clock-select vector is one-hot, with bit 0 for main, bit 1 for PLL and bit 2 for subclock.
- R11: An asynchronous reset applied in the middle of a wait returns the block at once to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock for all counting |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_pll_n_i | input | 1 | PLL select bit to write (0 requests PLL) |
| wr_sub_n_i | input | 1 | Subclock select bit to write (0 requests subclock) |
| wr_mul_i | input | MUL_W | Multiplier value to write |
| wr_wsel_i | input | 2 | Wait-select value to write |
| sub_tick_i | input | 1 | One-cycle marker of a subclock edge, asynchronous to clk_i |
| sel_pll_n_o | output | 1 | Stored PLL select bit |
| sel_sub_n_o | output | 1 | Stored subclock select bit |
| mul_o | output | MUL_W | Stored multiplier field, sent to the PLL |
| wsel_o | output | 2 | Stored wait-select field |
| mode_o | output | 2 | Committed mode code |
| clk_sel_o | output | 3 | One-hot select for the clock multiplexer |
| busy_o | output | 1 | A stabilization wait or tick synchronization is in progress |
| tbt_clr_o | output | 1 | One-cycle timebase-clear pulse |

## Verification
The hardest case to reach is a request that changes while a wait is already running. To see that the count restarts, the second write has to land well inside the first wait, and the mode must then be checked at the exact edge where the first wait would have ended. The directed part does this with the longest subclock wait. It also requests a PLL change and then withdraws it, to show the wait is dropped. The random part writes select pairs in every combination, and it places subclock ticks on a fixed grid so that both synchronized and timed paths finish. It then compares the mode, the one-hot select and the multiplier against a bench model of the register and the priority rule.

// File: rtl/cms_pkg.sv
package cms_pkg;

   localparam int LG_W = 5;

   typedef enum logic [1:0] {
      MODE_MAIN = 2'd0,
      MODE_PLL  = 2'd1,
      MODE_SUB  = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      PATH_NONE  = 2'd0,
      PATH_NOW   = 2'd1,
      PATH_TIMED = 2'd2,
      PATH_SYNC  = 2'd3
   } path_e;

   typedef struct packed {
      path_e           kind;
      logic [LG_W-1:0] lg;
      logic            clr;
   } path_t;

endpackage

// File: rtl/cms_sel_regs.sv
module cms_sel_regs
   import cms_pkg::*;
#(
   parameter int MUL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_pll_n_i,
   input  logic             wr_sub_n_i,
   input  logic [MUL_W-1:0] wr_mul_i,
   input  logic [1:0]       wr_wsel_i,
   output logic             pll_n_o,
   output logic             sub_n_o,
   output logic [MUL_W-1:0] mul_o,
   output logic [1:0]       wsel_o,
   output mode_e            tgt_o
);

   logic             pll_n_q, sub_n_q;
   logic [MUL_W-1:0] mul_q;
   logic [1:0]       wsel_q;
   logic             mul_open;

   // multiplier is writable only while the PLL is not requested
   assign mul_open = pll_n_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pll_n_q <= 1'b1;
         sub_n_q <= 1'b1;
         mul_q   <= '0;
         wsel_q  <= '0;
      end else if (wr_en_i) begin
         pll_n_q <= wr_pll_n_i;
         sub_n_q <= wr_sub_n_i;
         wsel_q  <= wr_wsel_i;
         if (mul_open) mul_q <= wr_mul_i;
      end
   end

   // subclock request outranks PLL request
   always_comb begin
      if (!sub_n_q)      tgt_o = MODE_SUB;
      else if (!pll_n_q) tgt_o = MODE_PLL;
      else               tgt_o = MODE_MAIN;
   end

   assign pll_n_o = pll_n_q;
   assign sub_n_o = sub_n_q;
   assign mul_o   = mul_q;
   assign wsel_o  = wsel_q;

endmodule

// File: rtl/cms_path_dec.sv
module cms_path_dec
   import cms_pkg::*;
#(
   parameter int PLL_LOCK_LOG2 = 14,
   parameter int WS0_LOG2      = 10,
   parameter int WS1_LOG2      = 13,
   parameter int WS2_LOG2      = 15,
   parameter int WS3_LOG2      = 17
) (
   input  mode_e      cur_i,
   input  mode_e      tgt_i,
   input  logic [1:0] wsel_i,
   output path_t      path_o
);

   localparam logic [LG_W-1:0] LG_PLL = LG_W'(PLL_LOCK_LOG2);
   localparam logic [LG_W-1:0] LG_W0  = LG_W'(WS0_LOG2);
   localparam logic [LG_W-1:0] LG_W1  = LG_W'(WS1_LOG2);
   localparam logic [LG_W-1:0] LG_W2  = LG_W'(WS2_LOG2);
   localparam logic [LG_W-1:0] LG_W3  = LG_W'(WS3_LOG2);

   logic [LG_W-1:0] ws_lg;

   always_comb begin
      case (wsel_i)
         2'd0:    ws_lg = LG_W0;
         2'd1:    ws_lg = LG_W1;
         2'd2:    ws_lg = LG_W2;
         default: ws_lg = LG_W3;
      endcase
   end

   always_comb begin
      path_o.kind = PATH_NONE;
      path_o.lg   = '0;
      path_o.clr  = 1'b0;
      if (cur_i != tgt_i) begin
         if (tgt_i == MODE_SUB) begin
            path_o.kind = PATH_SYNC;
         end else if (cur_i == MODE_PLL) begin
            path_o.kind = PATH_NOW;
         end else if (cur_i == MODE_MAIN) begin
            path_o.kind = PATH_TIMED;
            path_o.lg   = LG_PLL;
            path_o.clr  = 1'b1;
         end else begin
            path_o.kind = PATH_TIMED;
            path_o.lg   = ws_lg;
            path_o.clr  = (tgt_i == MODE_MAIN);
         end
      end
   end

endmodule

// File: rtl/cms_tick_sync.sv
module cms_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sh_q <= '0;
            end else begin
               for (int i = STAGES - 1; i > 0; i--) sh_q[i] <= sh_q[i-1];
               sh_q[0] <= d_i;
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cms_stab_timer.sv
module cms_stab_timer
   import cms_pkg::*;
#(
   parameter int CNT_W = 17
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clr_i,
   input  logic            run_i,
   input  logic [LG_W-1:0] lg_i,
   output logic            expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   last;

   assign last     = ({{CNT_W{1'b0}}, 1'b1} << lg_i) - 1'b1;
   assign expire_o = ({1'b0, cnt_q} == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
   import cms_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  mode_e           tgt_i,
   input  path_t           path_i,
   input  logic            expire_i,
   input  logic            tick_i,
   output mode_e           mode_o,
   output logic            busy_o,
   output logic            tbt_clr_o,
   output logic            tmr_clr_o,
   output logic            tmr_run_o,
   output logic [LG_W-1:0] lg_o
);

   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;

   st_e             st_q, st_d;
   mode_e           mode_q, mode_d, pend_q, pend_d;
   path_e           kind_q, kind_d;
   logic [LG_W-1:0] lg_q, lg_d;
   logic            clr_q, clr_d, tbt_q, tbt_d;
   logic            launch, done;

   assign done = (kind_q == PATH_SYNC) ? tick_i : expire_i;

   always_comb begin
      st_d      = st_q;
      mode_d    = mode_q;
      pend_d    = pend_q;
      kind_d    = kind_q;
      lg_d      = lg_q;
      clr_d     = clr_q;
      tbt_d     = 1'b0;
      tmr_clr_o = 1'b0;
      tmr_run_o = 1'b0;
      launch    = 1'b0;
      case (st_q)
         ST_IDLE: begin
            tmr_clr_o = 1'b1;
            launch    = (path_i.kind != PATH_NONE);
         end
         default: begin
            if (tgt_i == mode_q) begin
               st_d = ST_IDLE;
            end else if (tgt_i != pend_q) begin
               launch    = 1'b1;
               tmr_clr_o = 1'b1;
            end else if (done) begin
               mode_d = pend_q;
               tbt_d  = clr_q;
               st_d   = ST_IDLE;
            end else begin
               tmr_run_o = (kind_q == PATH_TIMED);
            end
         end
      endcase
      if (launch) begin
         if (path_i.kind == PATH_NOW) begin
            mode_d = tgt_i;
            tbt_d  = path_i.clr;
            st_d   = ST_IDLE;
         end else begin
            st_d   = ST_WAIT;
            pend_d = tgt_i;
            kind_d = path_i.kind;
            lg_d   = path_i.lg;
            clr_d  = path_i.clr;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_MAIN;
         pend_q <= MODE_MAIN;
         kind_q <= PATH_NONE;
         lg_q   <= '0;
         clr_q  <= 1'b0;
         tbt_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode_d;
         pend_q <= pend_d;
         kind_q <= kind_d;
         lg_q   <= lg_d;
         clr_q  <= clr_d;
         tbt_q  <= tbt_d;
      end
   end

   assign mode_o    = mode_q;
   assign busy_o    = (st_q == ST_WAIT);
   assign tbt_clr_o = tbt_q;
   assign lg_o      = lg_q;

endmodule

// File: rtl/clk_mode_switch.sv
module clk_mode_switch
   import cms_pkg::*;
#(
   parameter int MUL_W         = 2,
   parameter int PLL_LOCK_LOG2 = 14,
   parameter int WS0_LOG2      = 10,
   parameter int WS1_LOG2      = 13,
   parameter int WS2_LOG2      = 15,
   parameter int WS3_LOG2      = 17,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_pll_n_i,
   input  logic             wr_sub_n_i,
   input  logic [MUL_W-1:0] wr_mul_i,
   input  logic [1:0]       wr_wsel_i,
   input  logic             sub_tick_i,
   output logic             sel_pll_n_o,
   output logic             sel_sub_n_o,
   output logic [MUL_W-1:0] mul_o,
   output logic [1:0]       wsel_o,
   output logic [1:0]       mode_o,
   output logic [2:0]       clk_sel_o,
   output logic             busy_o,
   output logic             tbt_clr_o
);

   localparam int MAX_A = (WS0_LOG2 > WS1_LOG2) ? WS0_LOG2 : WS1_LOG2;
   localparam int MAX_B = (WS2_LOG2 > WS3_LOG2) ? WS2_LOG2 : WS3_LOG2;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = (MAX_C > PLL_LOCK_LOG2) ? MAX_C : PLL_LOCK_LOG2;

   generate
      if (MUL_W < 1 || MUL_W > 8) begin : g_bad_mul
         $error("MUL_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
      if (PLL_LOCK_LOG2 < 1 || WS0_LOG2 < 1 || WS1_LOG2 < 1 ||
          WS2_LOG2 < 1 || WS3_LOG2 < 1 || CNT_W > 30) begin : g_bad_wait
         $error("wait exponent out of range");
      end
   endgenerate

   mode_e           tgt, mode_q;
   path_t           path;
   logic            tick_s, expire, tmr_clr, tmr_run;
   logic [LG_W-1:0] lg;

   cms_sel_regs #(.MUL_W(MUL_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_pll_n_i (wr_pll_n_i),
      .wr_sub_n_i (wr_sub_n_i),
      .wr_mul_i   (wr_mul_i),
      .wr_wsel_i  (wr_wsel_i),
      .pll_n_o    (sel_pll_n_o),
      .sub_n_o    (sel_sub_n_o),
      .mul_o      (mul_o),
      .wsel_o     (wsel_o),
      .tgt_o      (tgt)
   );

   cms_path_dec #(
      .PLL_LOCK_LOG2 (PLL_LOCK_LOG2),
      .WS0_LOG2      (WS0_LOG2),
      .WS1_LOG2      (WS1_LOG2),
      .WS2_LOG2      (WS2_LOG2),
      .WS3_LOG2      (WS3_LOG2)
   ) u_dec (
      .cur_i  (mode_q),
      .tgt_i  (tgt),
      .wsel_i (wsel_o),
      .path_o (path)
   );

   cms_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sub_tick_i),
      .q_o    (tick_s)
   );

   cms_stab_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (tmr_clr),
      .run_i    (tmr_run),
      .lg_i     (lg),
      .expire_o (expire)
   );

   cms_mode_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tgt_i     (tgt),
      .path_i    (path),
      .expire_i  (expire),
      .tick_i    (tick_s),
      .mode_o    (mode_q),
      .busy_o    (busy_o),
      .tbt_clr_o (tbt_clr_o),
      .tmr_clr_o (tmr_clr),
      .tmr_run_o (tmr_run),
      .lg_o      (lg)
   );

   assign mode_o    = mode_q;
   assign clk_sel_o = {mode_q == MODE_SUB, mode_q == MODE_PLL, mode_q == MODE_MAIN};

endmodule

// File: rtl/clk_mode_switch_chk.sv
module clk_mode_switch_chk #(
   parameter int MUL_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sel_pll_n_o,
   input logic [MUL_W-1:0] mul_o,
   input logic [1:0]       mode_o,
   input logic [2:0]       clk_sel_o,
   input logic             busy_o,
   input logic             tbt_clr_o
);

   // R10: exactly one source selected, no unused mode code
   p_code_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(clk_sel_o) == 1) && (mode_o != 2'd3));

   // R8: multiplier frozen after any cycle with the PLL requested
   p_mul_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_pll_n_o |=> $stable(mul_o));

   // R7: clear pulse only on main->PLL or subclock->main commits
   p_clr_path_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbt_clr_o |-> ((mode_o == 2'd1 && $past(mode_o) == 2'd0) ||
                     (mode_o == 2'd0 && $past(mode_o) == 2'd2)));

   // R3: PLL is never entered without a preceding wait
   p_pll_waited_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd1 && $past(mode_o) != 2'd1) |-> $past(busy_o));

   // R5: subclock is entered only after the synchronizing wait
   p_sub_waited_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(busy_o));

endmodule

bind clk_mode_switch clk_mode_switch_chk #(.MUL_W(MUL_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sel_pll_n_o (sel_pll_n_o),
   .mul_o       (mul_o),
   .mode_o      (mode_o),
   .clk_sel_o   (clk_sel_o),
   .busy_o      (busy_o),
   .tbt_clr_o   (tbt_clr_o)
);

// File: tb/clk_mode_switch_tb_top.sv
`timescale 1ns/1ps
module clk_mode_switch_tb_top;

   localparam int MUL_W = 2;
   localparam int PLL_LG = 6;
   localparam int WS0 = 3, WS1 = 4, WS2 = 5, WS3 = 7;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic wr_en_i = 1'b0, wr_pll_n_i = 1'b1, wr_sub_n_i = 1'b1;
   logic [MUL_W-1:0] wr_mul_i = '0;
   logic [1:0] wr_wsel_i = '0;
   logic sub_tick_i = 1'b0;
   logic sel_pll_n_o, sel_sub_n_o, busy_o, tbt_clr_o;
   logic [MUL_W-1:0] mul_o;
   logic [1:0] wsel_o, mode_o;
   logic [2:0] clk_sel_o;

   int n_chk = 0, n_fail = 0, tbt_cnt = 0, tbt_ref = 0;
   bit finished = 0;
   bit m_pll_n = 1, m_sub_n = 1;
   int m_mul = 0;

   always #2.5 clk = ~clk;

   clk_mode_switch #(
      .MUL_W(MUL_W), .PLL_LOCK_LOG2(PLL_LG), .WS0_LOG2(WS0), .WS1_LOG2(WS1),
      .WS2_LOG2(WS2), .WS3_LOG2(WS3), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_pll_n_i(wr_pll_n_i),
      .wr_sub_n_i(wr_sub_n_i), .wr_mul_i(wr_mul_i), .wr_wsel_i(wr_wsel_i),
      .sub_tick_i(sub_tick_i), .sel_pll_n_o(sel_pll_n_o), .sel_sub_n_o(sel_sub_n_o),
      .mul_o(mul_o), .wsel_o(wsel_o), .mode_o(mode_o), .clk_sel_o(clk_sel_o),
      .busy_o(busy_o), .tbt_clr_o(tbt_clr_o)
   );

   always @(posedge clk) if (rst_ni && tbt_clr_o) tbt_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_mode(input bit pll_n, input bit sub_n);
      if (!sub_n) return 2;
      if (!pll_n) return 1;
      return 0;
   endfunction

   function automatic int exp_sel(input int m);
      return 1 << m;
   endfunction

   task automatic wr(input bit pll_n, input bit sub_n, input int mul, input int ws);
      @(negedge clk);
      wr_en_i = 1'b1; wr_pll_n_i = pll_n; wr_sub_n_i = sub_n;
      wr_mul_i = MUL_W'(mul); wr_wsel_i = 2'(ws);
      @(negedge clk);
      wr_en_i = 1'b0;
      if (m_pll_n) m_mul = mul;
      m_pll_n = pll_n; m_sub_n = sub_n;
   endtask

   task automatic tick_pulse();
      @(negedge clk); sub_tick_i = 1'b1;
      @(negedge clk); sub_tick_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_ni = 1'b0;
      idle(2);
      rst_ni = 1'b1;
      m_pll_n = 1; m_sub_n = 1; m_mul = 0;
   endtask

   task automatic chk_reset_state(input string tag);
      chk({tag, " sel_pll_n"}, sel_pll_n_o, 1);
      chk({tag, " sel_sub_n"}, sel_sub_n_o, 1);
      chk({tag, " mul"}, mul_o, 0);
      chk({tag, " wsel"}, wsel_o, 0);
      chk({tag, " mode"}, mode_o, 0);
      chk({tag, " clk_sel"}, clk_sel_o, 1);
      chk({tag, " busy"}, busy_o, 0);
      chk({tag, " tbt_clr"}, tbt_clr_o, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      idle(3);
      rst_ni = 1'b1;
      idle(1);
      chk_reset_state("R1");

      // R3 main -> PLL, fixed wait; multiplier loads since PLL not yet requested
      tbt_ref = tbt_cnt;
      wr(0, 1, 2, 0);
      idle(1 << PLL_LG);
      chk("R3 mode before lock", mode_o, 0);
      chk("R3 busy during lock", busy_o, 1);
      idle(1);
      chk("R3 mode after lock", mode_o, 1);
      chk("R3 busy after lock", busy_o, 0);
      chk("R10 clk_sel pll", clk_sel_o, 3'b010);
      chk("R8 mul loaded", mul_o, 2);
      idle(2);
      chk("R7 clear on main->pll", tbt_cnt - tbt_ref, 1);

      // R8 lock, R6 immediate return to main
      wr(0, 1, 1, 0);
      chk("R8 mul locked while pll", mul_o, 2);
      tbt_ref = tbt_cnt;
      wr(1, 1, 3, 0);
      chk("R6 mode before commit", mode_o, 1);
      chk("R8 mul locked on deselect", mul_o, 2);
      idle(1);
      chk("R6 main next edge", mode_o, 0);
      chk("R6 busy stays low", busy_o, 0);
      wr(1, 1, 3, 0);
      chk("R8 mul loads when free", mul_o, 3);
      idle(2);
      chk("R7 no clear on pll->main", tbt_cnt - tbt_ref, 0);
      wr(0, 1, 3, 0);
      idle((1 << PLL_LG) + 4);
      chk("R3 back in pll", mode_o, 1);

      // R2 and R5: both bits 0 -> subclock, needs tick
      tbt_ref = tbt_cnt;
      wr(0, 0, 0, 0);
      idle(30);
      chk("R5 no commit without tick", mode_o, 1);
      chk("R5 busy waiting for tick", busy_o, 1);
      tick_pulse();
      chk("R2 subclock wins", mode_o, 2);
      chk("R10 clk_sel sub", clk_sel_o, 3'b100);

      // R4 subclock -> PLL, wait-select 1
      wr(0, 1, 0, 1);
      idle(1 << WS1);
      chk("R4 sub->pll before", mode_o, 2);
      idle(1);
      chk("R4 sub->pll after", mode_o, 1);
      idle(2);
      chk("R7 no clear sub->pll", tbt_cnt - tbt_ref, 0);

      // back to subclock, then R4/R7 subclock -> main, wait-select 2
      wr(1, 0, 0, 2);
      tick_pulse();
      chk("R5 pll->sub", mode_o, 2);
      tbt_ref = tbt_cnt;
      wr(1, 1, 0, 2);
      idle(1 << WS2);
      chk("R4 sub->main before", mode_o, 2);
      idle(1);
      chk("R4 sub->main after", mode_o, 0);
      chk("R10 clk_sel main", clk_sel_o, 3'b001);
      idle(2);
      chk("R7 clear on sub->main", tbt_cnt - tbt_ref, 1);

      // R9 retarget restarts the count
      wr(1, 0, 0, 3);
      tick_pulse();
      tbt_ref = tbt_cnt;
      wr(0, 1, 0, 3);
      idle(50);
      wr(1, 1, 0, 3);
      idle(1 << WS3);
      chk("R9 restarted wait", mode_o, 2);
      idle(1);
      chk("R9 commit after restart", mode_o, 0);
      idle(2);
      chk("R9 single clear", tbt_cnt - tbt_ref, 1);

      // R9 withdraw request drops the wait
      wr(0, 1, 0, 0);
      idle(10);
      wr(1, 1, 0, 0);
      idle(1);
      chk("R9 abort busy", busy_o, 0);
      idle(80);
      chk("R9 abort stays main", mode_o, 0);

      // R11 reset mid-wait
      wr(0, 1, 1, 2);
      idle(20);
      chk("R11 waiting", busy_o, 1);
      @(negedge clk); rst_ni = 1'b0;
      #1;
      chk_reset_state("R11");
      idle(2);
      rst_ni = 1'b1;
      m_pll_n = 1; m_sub_n = 1; m_mul = 0;

      // random: R2, R8, R10 against the bench model
      for (int it = 0; it < 14; it++) begin
         bit rp, rs;
         int rm, rw, em;
         rp = 1'($urandom); rs = 1'($urandom);
         rm = int'($urandom % 4); rw = int'($urandom % 4);
         wr(rp, rs, rm, rw);
         for (int c = 0; c < 170; c++) begin
            @(negedge clk);
            sub_tick_i = (c % 20 == 10);
         end
         em = exp_mode(m_pll_n, m_sub_n);
         chk("R2 random mode", mode_o, em);
         chk("R10 random clk_sel", clk_sel_o, exp_sel(em));
         chk("R8 random mul", mul_o, m_mul);
         chk("R9 random settled", busy_o, 0);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule